// File: doc/BRIEF.md
# Linear CCD Line Clock Sequencer

This block drives the digital clock pins of a three-colour linear CCD from a fast system clock. It produces one transfer-gate pulse that all three colour rows share, a pair of antiphase shift-register clocks, and a short reset-gate pulse once per pixel period. The reset-gate pulse never stops, so it also runs while the sensor is idle and while the transfer gate is open. Along with the clocks it outputs a pixel strobe, a 1-based pixel index and a class tag. A downstream sampler uses these to know which samples are dummy, optical black or image pixels.

A line starts in one of two ways: through a one-cycle request, or back to back when the auto-run input is high. A request that arrives during a line is held and served at the next line boundary. Each line runs in this order:
1. A leading guard with shift clock 1 parked high.
2. The transfer-gate pulse.
3. A trailing guard.
4. Alignment to the pixel grid.
5. A fixed number of pixel periods.

Pixel period, transfer width, guard length, reset width and reset offset come in as cycle counts. Each count is raised to a floor that is derived from the clock-frequency parameter. The floors are: pixel period 250 ns, transfer gate 3000 ns, guard 900 ns, reset width 20 ns, reset offset 110 ns. At 125 MHz these give 32, 375, 113, 3 and 14 cycles.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted and right after it: `tg_o`=0, `phi1_o`=1, `phi2_o`=0, `rg_o`=0, `pix_vld_o`=0, `line_done_o`=0.
- R2: `phi2_o` is always the complement of `phi1_o`.
- R3: `tg_o` stays high for exactly T = max(`tg_wid_i`, floor) cycles. While it is high, `phi1_o`=1 and `pix_vld_o`=0.
- R4: `tg_o` rises at least G = max(`guard_i`, floor) cycles after the last `phi1_o` edge. `phi1_o` first falls at least G cycles after `tg_o` falls.
- R5: During pixels, `phi1_o` rises every P = max(`pix_per_i`, floor) cycles and stays high for P/2 cycles, rounded down. A pixel starts when `phi1_o` rises, or when `pix_vld_o` rises for pixel 1.
- R6: `rg_o` rises S = max(`rg_sep_i`, floor) cycles after each pixel start and stays high for W = max(`rg_wid_i`, floor) cycles. It keeps pulsing while idle and while `tg_o` is high.
- R7: Each line has exactly LINE_PIX pixels. `pix_idx_o` starts at 1 and steps by one per pixel, with `pix_vld_o` high throughout.
- R8: `pix_cls_o` is 1 (optical black) for indices OB_FIRST..OB_LAST, 2 (image) for VAL_FIRST..VAL_LAST, and 0 (dummy) otherwise and whenever `pix_vld_o` is low.
- R9: `line_done_o` is a one-cycle pulse in the final cycle of pixel LINE_PIX.
- R10: Without a request and with `auto_i` low, no line starts. Any number of requests during a line yield exactly one further line.
- R11: With `auto_i` high, lines follow back to back, and `tg_o` rises exactly G cycles after the last pixel ends.
- R12: Counts below their floors are clamped up. An all-zero configuration yields P=32, T=375, G=113, W=3, S=14 at 125 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_i | input | 1 | Run lines back to back |
| start_i | input | 1 | One-cycle line request |
| pix_per_i | input | CNT_W | Pixel period in cycles |
| rg_wid_i | input | CNT_W | Reset-gate high width in cycles |
| rg_sep_i | input | CNT_W | Offset from pixel start to reset-gate rise |
| tg_wid_i | input | CNT_W | Transfer-gate high width in cycles |
| guard_i | input | CNT_W | Guard between transfer and shift edges |
| tg_o | output | 1 | Transfer-gate clock, shared by all rows |
| phi1_o | output | 1 | Shift clock 1 |
| phi2_o | output | 1 | Shift clock 2 |
| rg_o | output | 1 | Reset-gate pulse |
| pix_vld_o | output | 1 | A pixel period is in progress |
| pix_idx_o | output | IDX_W | Pixel index, 1-based |
| pix_cls_o | output | 2 | 0 dummy, 1 optical black, 2 image |
| line_done_o | output | 1 | Last-pixel pulse |

## Verification
The assertions assume the configuration inputs are held steady from the moment a line launches until it ends. The stimulus therefore changes them only while the block is idle. Both the stimulus and the assertions also assume S + W stays below P, so that each reset pulse fits inside its pixel period. The random configurations are drawn under that bound. Requests and `auto_i` are driven at cycle granularity at any point in the line, which exercises the pending-request path at arbitrary pixel phases.

// File: rtl/ccd_tmg_pkg.sv
package ccd_tmg_pkg;
  typedef enum logic [1:0] {
    CLS_DUMMY = 2'd0,
    CLS_OB    = 2'd1,
    CLS_VALID = 2'd2
  } pix_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_SHIFT
  } line_st_e;

  // ceiling of hz * ps / 1e12
  function automatic longint unsigned ceil_cycles(longint unsigned hz, longint unsigned ps);
    return (hz * ps + 64'd999_999_999_999) / 64'd1_000_000_000_000;
  endfunction
endpackage

// File: rtl/ccd_cnt_clamp.sv
module ccd_cnt_clamp #(
  parameter int          CNT_W = 16,
  parameter int unsigned MIN   = 1
) (
  input  logic [CNT_W-1:0] raw_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam logic [CNT_W-1:0] MinC = CNT_W'(MIN);
  assign eff_o = (raw_i < MinC) ? MinC : raw_i;
endmodule

// File: rtl/ccd_pix_phase.sv
module ccd_pix_phase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] rg_sep_i,
  input  logic [CNT_W-1:0] rg_wid_i,
  input  logic             hold_i,
  output logic             ph_last_o,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             rg_o
);
  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] half;
  logic [CNT_W:0]   rg_end;

  assign ph_last_o = ph_q >= (per_i - 1'b1);
  assign half      = per_i >> 1;
  assign rg_end    = {1'b0, rg_sep_i} + {1'b0, rg_wid_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (ph_last_o) ph_q <= '0;
    else                ph_q <= ph_q + 1'b1;
  end

  // separate decodes so antiphase is a checked property
  assign phi1_o = hold_i | (ph_q < half);
  assign phi2_o = ~hold_i & (ph_q >= half);
  assign rg_o   = (ph_q >= rg_sep_i) && ({1'b0, ph_q} < rg_end);

  p_phase_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_last_o |=> (ph_q == '0));
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tmg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LINE_PIX = 5369,
  parameter int IDX_W    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             start_i,
  input  logic             ph_last_i,
  input  logic [CNT_W-1:0] tg_cyc_i,
  input  logic [CNT_W-1:0] guard_i,
  output logic             hold_o,
  output logic             tg_o,
  output logic             shift_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(LINE_PIX);

  line_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, launch, want, last_pix;

  assign want     = pend_q | auto_i;
  assign last_pix = (idx_q == LastIdx);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    launch = 1'b0;
    unique case (st_q)
      ST_IDLE: if (want && ph_last_i) begin
        st_d = ST_LEAD; cnt_d = '0; launch = 1'b1;
      end
      ST_LEAD: if (cnt_q >= guard_i - 1'b1) begin
        st_d = ST_XFER; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_XFER: if (cnt_q >= tg_cyc_i - 1'b1) begin
        st_d = ST_TRAIL; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_TRAIL: begin
        if (cnt_q >= guard_i - 1'b1) begin
          if (ph_last_i) begin st_d = ST_SHIFT; idx_d = IDX_W'(1); end
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SHIFT: if (ph_last_i) begin
        if (last_pix) begin
          idx_d = '0;
          cnt_d = '0;
          if (want) begin st_d = ST_LEAD; launch = 1'b1; end
          else      st_d = ST_IDLE;
        end else idx_d = idx_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      pend_q <= (pend_q & ~launch) | start_i;
    end
  end

  assign hold_o  = (st_q != ST_SHIFT);
  assign tg_o    = (st_q == ST_XFER);
  assign shift_o = (st_q == ST_SHIFT);
  assign idx_o   = idx_q;
  assign done_o  = shift_o & ph_last_i & last_pix;

  p_lead_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAD && cnt_q < guard_i - 1'b1) |=> (st_q == ST_LEAD));
  p_trail_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAIL && cnt_q < guard_i - 1'b1) |=> (st_q == ST_TRAIL));
  p_xfer_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && st_d != ST_XFER) |=> (st_q == ST_TRAIL));
  p_no_idle_launch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !pend_q && !auto_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ccd_pix_class.sv
module ccd_pix_class
  import ccd_tmg_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int OB_FIRST  = 14,
  parameter int OB_LAST   = 62,
  parameter int VAL_FIRST = 65,
  parameter int VAL_LAST  = 5364
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output pix_cls_e         cls_o
);
  logic in_ob, in_val;
  assign in_ob  = (idx_i >= IDX_W'(OB_FIRST))  && (idx_i <= IDX_W'(OB_LAST));
  assign in_val = (idx_i >= IDX_W'(VAL_FIRST)) && (idx_i <= IDX_W'(VAL_LAST));

  always_comb begin
    if (!vld_i)      cls_o = CLS_DUMMY;
    else if (in_val) cls_o = CLS_VALID;
    else if (in_ob)  cls_o = CLS_OB;
    else             cls_o = CLS_DUMMY;
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tmg_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int          CNT_W     = 16,
  parameter int          LINE_PIX  = 5369,
  parameter int          OB_FIRST  = 14,
  parameter int          OB_LAST   = 62,
  parameter int          VAL_FIRST = 65,
  parameter int          VAL_LAST  = 5364,
  localparam int         IDX_W     = $clog2(LINE_PIX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pix_per_i,
  input  logic [CNT_W-1:0] rg_wid_i,
  input  logic [CNT_W-1:0] rg_sep_i,
  input  logic [CNT_W-1:0] tg_wid_i,
  input  logic [CNT_W-1:0] guard_i,
  output logic             tg_o,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             rg_o,
  output logic             pix_vld_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic [1:0]       pix_cls_o,
  output logic             line_done_o
);
  localparam int NCFG = 5;
  // floors in ps: pixel, reset width, reset offset, transfer, guard
  localparam longint unsigned FLOOR_PS [NCFG] = '{250_000, 20_000, 110_000, 3_000_000, 900_000};

  logic [CNT_W-1:0] cfg_raw [NCFG];
  logic [CNT_W-1:0] cfg_eff [NCFG];

  assign cfg_raw[0] = pix_per_i;
  assign cfg_raw[1] = rg_wid_i;
  assign cfg_raw[2] = rg_sep_i;
  assign cfg_raw[3] = tg_wid_i;
  assign cfg_raw[4] = guard_i;

  for (genvar g = 0; g < NCFG; g++) begin : g_clamp
    ccd_cnt_clamp #(
      .CNT_W(CNT_W),
      .MIN  (int'(ceil_cycles(64'(CLK_HZ), FLOOR_PS[g])))
    ) i_clamp (
      .raw_i(cfg_raw[g]),
      .eff_o(cfg_eff[g])
    );
  end

  logic             ph_last, hold, seq_tg, seq_shift, seq_done;
  logic             c_phi1, c_phi2, c_rg;
  logic [IDX_W-1:0] seq_idx;
  pix_cls_e         c_cls;

  ccd_pix_phase #(.CNT_W(CNT_W)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_i    (cfg_eff[0]),
    .rg_sep_i (cfg_eff[2]),
    .rg_wid_i (cfg_eff[1]),
    .hold_i   (hold),
    .ph_last_o(ph_last),
    .phi1_o   (c_phi1),
    .phi2_o   (c_phi2),
    .rg_o     (c_rg)
  );

  ccd_line_seq #(.CNT_W(CNT_W), .LINE_PIX(LINE_PIX), .IDX_W(IDX_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_i   (auto_i),
    .start_i  (start_i),
    .ph_last_i(ph_last),
    .tg_cyc_i (cfg_eff[3]),
    .guard_i  (cfg_eff[4]),
    .hold_o   (hold),
    .tg_o     (seq_tg),
    .shift_o  (seq_shift),
    .idx_o    (seq_idx),
    .done_o   (seq_done)
  );

  ccd_pix_class #(
    .IDX_W(IDX_W), .OB_FIRST(OB_FIRST), .OB_LAST(OB_LAST),
    .VAL_FIRST(VAL_FIRST), .VAL_LAST(VAL_LAST)
  ) i_class (
    .vld_i(seq_shift),
    .idx_i(seq_idx),
    .cls_o(c_cls)
  );

  // glitch-free pins: every output leaves a flop, all with equal latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tg_o        <= 1'b0;
      phi1_o      <= 1'b1;
      phi2_o      <= 1'b0;
      rg_o        <= 1'b0;
      pix_vld_o   <= 1'b0;
      pix_idx_o   <= '0;
      pix_cls_o   <= CLS_DUMMY;
      line_done_o <= 1'b0;
    end else begin
      tg_o        <= seq_tg;
      phi1_o      <= c_phi1;
      phi2_o      <= c_phi2;
      rg_o        <= c_rg;
      pix_vld_o   <= seq_shift;
      pix_idx_o   <= seq_idx;
      pix_cls_o   <= c_cls;
      line_done_o <= seq_done;
    end
  end

  p_antiphase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_o != phi2_o);
  p_tg_parked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o |-> (phi1_o && !pix_vld_o));
  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> (pix_idx_o >= IDX_W'(1) && pix_idx_o <= IDX_W'(LINE_PIX)));
  p_cls_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> (pix_cls_o == CLS_DUMMY));
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);
  p_done_in_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (pix_vld_o && pix_idx_o == IDX_W'(LINE_PIX)));
endmodule

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;
  localparam int B_LINE  = 30;
  localparam int B_OB0   = 4;
  localparam int B_OB1   = 8;
  localparam int B_VAL0  = 11;
  localparam int B_VAL1  = 25;
  localparam int B_IDX_W = $clog2(B_LINE + 1);
  localparam int WD_CYC  = 190_000;
  // floors at 125 MHz
  localparam int F_PER = 32, F_RGW = 3, F_SEP = 14, F_TG = 375, F_GD = 113;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_r = 1'b0, start_r = 1'b0;
  logic [15:0] per_r = '0, rgw_r = '0, sep_r = '0, tgw_r = '0, gd_r = '0;
  logic tg, phi1, phi2, rg, vld, done;
  logic [B_IDX_W-1:0] idx;
  logic [1:0] cls;

  always #4 clk = ~clk;

  ccd_line_timer #(
    .LINE_PIX(B_LINE), .OB_FIRST(B_OB0), .OB_LAST(B_OB1),
    .VAL_FIRST(B_VAL0), .VAL_LAST(B_VAL1)
  ) i_ccd_line_timer (
    .clk_i(clk), .rst_ni(rst_n), .auto_i(auto_r), .start_i(start_r),
    .pix_per_i(per_r), .rg_wid_i(rgw_r), .rg_sep_i(sep_r),
    .tg_wid_i(tgw_r), .guard_i(gd_r),
    .tg_o(tg), .phi1_o(phi1), .phi2_o(phi2), .rg_o(rg),
    .pix_vld_o(vld), .pix_idx_o(idx), .pix_cls_o(cls), .line_done_o(done)
  );

  int n_vec = 0, n_fail = 0;
  int exp_p, exp_w, exp_s, exp_t, exp_g;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(int v, int mn);
    return (v < mn) ? mn : v;
  endfunction

  function automatic int exp_cls(int i);
    if (i >= B_VAL0 && i <= B_VAL1) return 2;
    if (i >= B_OB0 && i <= B_OB1) return 1;
    return 0;
  endfunction

  task automatic set_cfg(int p, int w, int s, int t, int g);
    per_r = 16'(p); rgw_r = 16'(w); sep_r = 16'(s); tgw_r = 16'(t); gd_r = 16'(g);
    exp_p = clampv(p, F_PER); exp_w = clampv(w, F_RGW); exp_s = clampv(s, F_SEP);
    exp_t = clampv(t, F_TG);  exp_g = clampv(g, F_GD);
  endtask

  // monitor state
  int  cyc = 0;
  bit  mon_en = 1'b0;
  bit  p_tg = 0, p_phi1 = 1, p_rg = 0, p_vld = 0, p_done = 0;
  int  t_phi1_chg = 0, t_tg_rise = 0, t_tg_fall = 0, t_pix = 0, t_rg = 0;
  bit  wait_fall = 0, rg_open = 0;
  int  rg_in_tg = 0, rg_rises = 0, tg_rises = 0, done_cnt = 0;
  int  exp_idx = 0, pix_cnt = 0, last_lead_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc >= WD_CYC) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_CYC);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
    if (mon_en) begin
      chk(phi2 == !phi1, "R2 antiphase", int'(phi2), int'(!phi1));
      if (rg && !p_rg) rg_rises++;
      if (tg && !p_tg) begin
        tg_rises++;
        last_lead_gap = cyc - t_phi1_chg;
        chk(last_lead_gap >= exp_g, "R4 lead guard", last_lead_gap, exp_g);
        t_tg_rise = cyc; rg_in_tg = 0;
      end
      if (tg && rg && !p_rg) rg_in_tg++;
      if (!tg && p_tg) begin
        chk(cyc - t_tg_rise == exp_t, "R3 tg width", cyc - t_tg_rise, exp_t);
        chk(rg_in_tg >= 1, "R6 rg during transfer", rg_in_tg, 1);
        t_tg_fall = cyc; wait_fall = 1;
      end
      if (phi1 != p_phi1) begin
        if (!phi1 && wait_fall) begin
          chk(cyc - t_tg_fall >= exp_g, "R4 trail guard", cyc - t_tg_fall, exp_g);
          wait_fall = 0;
        end
        t_phi1_chg = cyc;
      end
      if (vld && !p_vld) begin
        chk(int'(idx) == 1, "R7 first index", int'(idx), 1);
        exp_idx = 1; pix_cnt = 1; t_pix = cyc;
      end else if (vld && phi1 && !p_phi1) begin
        chk(cyc - t_pix == exp_p, "R5 pixel period", cyc - t_pix, exp_p);
        chk(int'(idx) == exp_idx + 1, "R7 index step", int'(idx), exp_idx + 1);
        exp_idx++; pix_cnt++; t_pix = cyc;
      end
      if (vld && p_vld && !phi1 && p_phi1)
        chk(cyc - t_pix == exp_p / 2, "R5 phi1 high time", cyc - t_pix, exp_p / 2);
      if (vld && rg && !p_rg) begin
        chk(cyc - t_pix == exp_s, "R6 rg offset", cyc - t_pix, exp_s);
        t_rg = cyc; rg_open = 1;
      end
      if (!rg && p_rg && rg_open) begin
        chk(cyc - t_rg == exp_w, "R6 rg width", cyc - t_rg, exp_w);
        rg_open = 0;
      end
      if (vld) chk(int'(cls) == exp_cls(int'(idx)), "R8 class", int'(cls), exp_cls(int'(idx)));
      if (done) begin
        done_cnt++;
        chk(vld && int'(idx) == B_LINE, "R9 done on last pixel", int'(idx), B_LINE);
        chk(pix_cnt == B_LINE, "R7 pixels per line", pix_cnt, B_LINE);
        chk(!p_done, "R9 done single cycle", int'(p_done), 0);
      end
    end
    p_tg = tg; p_phi1 = phi1; p_rg = rg; p_vld = vld; p_done = done;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start_r = 1'b1;
    @(posedge clk); #1 start_r = 1'b0;
  endtask

  task automatic wait_done(int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int tr0, dn0, rr0;
    void'($urandom(32'd1729));
    set_cfg(125, 7, 32, 1250, 125);
    idle_cycles(4);
    // R1 reset values
    chk(!tg && phi1 && !phi2 && !rg, "R1 clocks in reset", {tg, phi1, phi2, rg}, 4'b0100);
    chk(!vld && !done, "R1 strobes in reset", {vld, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!tg && !vld && !done, "R1 after release", {tg, vld, done}, 0);
    mon_en = 1'b1;

    // R10 idle: no line without request, R6 rg keeps running
    rr0 = rg_rises;
    idle_cycles(800);
    chk(tg_rises == 0, "R10 no line without request", tg_rises, 0);
    chk(rg_rises - rr0 >= 5, "R6 rg while idle", rg_rises - rr0, 5);

    // nominal line
    pulse_start();
    wait_done(1);
    idle_cycles(300);

    // R12 all-zero config clamps to floors
    set_cfg(0, 0, 0, 0, 0);
    chk(exp_p == 32 && exp_t == 375 && exp_g == 113, "R12 floor values", exp_p, 32);
    pulse_start();
    wait_done(2);
    idle_cycles(300);

    // R10 two requests during a line -> exactly one more line
    set_cfg(40, 4, 15, 400, 120);
    tr0 = tg_rises; dn0 = done_cnt;
    pulse_start();
    while (!vld) @(negedge clk);
    idle_cycles(50);
    pulse_start();
    idle_cycles(70);
    pulse_start();
    wait_done(dn0 + 2);
    idle_cycles(2000);
    chk(tg_rises - tr0 == 2, "R10 queued request count", tg_rises - tr0, 2);
    chk(done_cnt - dn0 == 2, "R10 lines completed", done_cnt - dn0, 2);

    // random configurations
    for (int k = 0; k < 4; k++) begin
      int p, w, s;
      p = 40 + int'($urandom_range(60));
      w = int'($urandom_range(10));
      s = int'($urandom_range(p - clampv(w, F_RGW) - 2));
      set_cfg(p, w, s, int'($urandom_range(900)), int'($urandom_range(200)));
      dn0 = done_cnt;
      pulse_start();
      wait_done(dn0 + 1);
      idle_cycles(200);
    end

    // R11 auto-run back to back, exact lead guard
    set_cfg(36, 3, 14, 380, 115);
    dn0 = done_cnt;
    tr0 = tg_rises;
    @(posedge clk); #1 auto_r = 1'b1;
    wait_done(dn0 + 1);
    while (tg_rises == tr0 + 1) @(negedge clk);
    chk(last_lead_gap == exp_g, "R11 back-to-back lead", last_lead_gap, exp_g);
    wait_done(dn0 + 2);
    @(posedge clk); #1 auto_r = 1'b0;
    wait_done(dn0 + 3);
    tr0 = tg_rises;
    idle_cycles(1500);
    chk(tg_rises == tr0, "R10 stops after auto drops", tg_rises, tr0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule